// File: doc/BRIEF.md
# Data-Hazard Forwarding and Load-Use Interlock Unit

This block decides, for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback), where each of the two ALU operands of the instruction in execute should come from. The choices are the register file, the result held in the execute/memory pipeline register, or the result held in the memory/writeback pipeline register. Each producer's destination register number and write flag travel with it down the pipeline. The unit compares these carried numbers against the source register numbers of the consumer.

The unit also detects a load whose destination is read by the instruction right behind it, which is still in decode. When it finds one, it freezes the PC and the fetch/decode register for one cycle and zeroes the control fields entering execute. This inserts a single bubble, after which normal forwarding supplies the loaded value. The register file is assumed to write in the first half of a cycle and read in the second. A producer three instructions ahead therefore needs no bypass, and the unit has no input for it. The block is purely combinational.

Top module: `hz_unit`

## Requirements
- R1: When the execute/memory producer has its write flag set, a non-zero destination, and a destination equal to an execute-stage source, that operand's selector is 2'b10.
- R2: When only the memory/writeback producer matches an execute-stage source (write flag set, non-zero destination), that operand's selector is 2'b01.
- R3: When both producers match the same source, the selector is 2'b10, so the younger result wins.
- R4: A source or destination of register 0 never causes forwarding, and the selector stays 2'b00.
- R5: A producer whose write flag is clear is ignored, even if its destination number matches.
- R6: With no qualifying match, the selector is 2'b00 (register file).
- R7: The two operand selectors are computed independently. A match on one operand has no effect on the other.
- R8: When the execute-stage instruction is a load (memory-read flag set) with a non-zero destination equal to either decode-stage source, the unit does three things: it drives the PC write enable low, drives the fetch/decode write enable low, and drives the bubble output high.
- R9: In every other case, both write enables are high and the bubble is low. This includes a matching register when the memory-read flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src1 | input | REG_AW | First source register of the decode-stage instruction |
| id_src2 | input | REG_AW | Second source register of the decode-stage instruction |
| ex_src1 | input | REG_AW | First source register of the execute-stage instruction |
| ex_src2 | input | REG_AW | Second source register of the execute-stage instruction |
| ex_dst | input | REG_AW | Destination carried in the decode/execute register |
| ex_is_load | input | 1 | Memory-read flag of the execute-stage instruction |
| exm_dst | input | REG_AW | Destination carried in the execute/memory register |
| exm_wr | input | 1 | Register-write flag in the execute/memory register |
| mwb_dst | input | REG_AW | Destination carried in the memory/writeback register |
| mwb_wr | input | 1 | Register-write flag in the memory/writeback register |
| opnd_a_sel | output | 2 | Source select for ALU operand A (00 file, 10 exe/mem, 01 mem/wb) |
| opnd_b_sel | output | 2 | Source select for ALU operand B (same encoding) |
| pc_wr_en | output | 1 | PC write enable, low during a load-use hold |
| ifid_wr_en | output | 1 | Fetch/decode register write enable, low during a hold |
| idex_bubble | output | 1 | High to zero the control fields entering execute |

## Verification
The unit holds no state, so every output is due in the same cycle the stage information is presented, with zero register delays. The bench drives new stage fields just after a rising edge and samples all outputs at the following falling edge, half a period later. By then the combinational paths have settled, and no result depends on the order in which processes run at a clock edge. Directed vectors cover priority, register 0, cleared write flags and the load-use boundary. Seeded random vectors then draw register numbers from a narrow range so that matches are frequent.

// File: rtl/hz_pkg.sv
package hz_pkg;

   localparam int SEL_W = 2;

   typedef enum logic [SEL_W-1:0] {
      FWD_RF  = 2'b00,
      FWD_MWB = 2'b01,
      FWD_EXM = 2'b10
   } fwd_sel_e;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
   parameter int REG_AW    = 5,
   parameter bit ZERO_SINK = 1'b1
) (
   input  logic [REG_AW-1:0] src,
   input  logic [REG_AW-1:0] dst,
   input  logic              wr,
   output logic              hit
);

   localparam logic [REG_AW-1:0] ZERO_REG = '0;

   logic same;
   assign same = (src == dst);

   generate
      if (ZERO_SINK) begin : g_sink
         assign hit = wr && same && (dst != ZERO_REG);
      end else begin : g_plain
         assign hit = wr && same;
      end
   endgenerate

endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
   import hz_pkg::*;
(
   input  logic     hit_exm,
   input  logic     hit_mwb,
   output fwd_sel_e sel
);

   always_comb begin
      if (hit_exm)      sel = FWD_EXM;
      else if (hit_mwb) sel = FWD_MWB;
      else              sel = FWD_RF;
   end

endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int REG_AW    = 5,
   parameter bit ZERO_SINK = 1'b1
) (
   input  logic [REG_AW-1:0] id_src1,
   input  logic [REG_AW-1:0] id_src2,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_is_load,
   output logic              hold
);

   localparam int NSRC = 2;

   logic [REG_AW-1:0] srcs [NSRC];
   logic [NSRC-1:0]   hits;

   assign srcs[0] = id_src1;
   assign srcs[1] = id_src2;

   generate
      for (genvar g = 0; g < NSRC; g++) begin : g_cmp
         hz_match #(.REG_AW(REG_AW), .ZERO_SINK(ZERO_SINK)) u_m (
            .src (srcs[g]),
            .dst (ex_dst),
            .wr  (ex_is_load),
            .hit (hits[g])
         );
      end
   endgenerate

   assign hold = |hits;

endmodule

// File: rtl/hz_unit.sv
module hz_unit
   import hz_pkg::*;
#(
   parameter int REG_AW    = 5,
   parameter bit ZERO_SINK = 1'b1
) (
   input  logic [REG_AW-1:0] id_src1,
   input  logic [REG_AW-1:0] id_src2,
   input  logic [REG_AW-1:0] ex_src1,
   input  logic [REG_AW-1:0] ex_src2,
   input  logic [REG_AW-1:0] ex_dst,
   input  logic              ex_is_load,
   input  logic [REG_AW-1:0] exm_dst,
   input  logic              exm_wr,
   input  logic [REG_AW-1:0] mwb_dst,
   input  logic              mwb_wr,
   output logic [1:0]        opnd_a_sel,
   output logic [1:0]        opnd_b_sel,
   output logic              pc_wr_en,
   output logic              ifid_wr_en,
   output logic              idex_bubble
);

   localparam int NOPND = 2;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hz_unit: REG_AW must lie in 1..8");
      end
      if (SEL_W != 2) begin : g_bad_sel
         $error("hz_unit: selector width must be 2");
      end
   endgenerate

   logic [REG_AW-1:0] opnd_src [NOPND];
   fwd_sel_e          opnd_sel [NOPND];
   logic [NOPND-1:0]  hit_exm;
   logic [NOPND-1:0]  hit_mwb;
   logic              hold;

   assign opnd_src[0] = ex_src1;
   assign opnd_src[1] = ex_src2;

   generate
      for (genvar g = 0; g < NOPND; g++) begin : g_opnd
         hz_match #(.REG_AW(REG_AW), .ZERO_SINK(ZERO_SINK)) u_exm (
            .src (opnd_src[g]),
            .dst (exm_dst),
            .wr  (exm_wr),
            .hit (hit_exm[g])
         );
         hz_match #(.REG_AW(REG_AW), .ZERO_SINK(ZERO_SINK)) u_mwb (
            .src (opnd_src[g]),
            .dst (mwb_dst),
            .wr  (mwb_wr),
            .hit (hit_mwb[g])
         );
         hz_fwd_sel u_sel (
            .hit_exm (hit_exm[g]),
            .hit_mwb (hit_mwb[g]),
            .sel     (opnd_sel[g])
         );
      end
   endgenerate

   hz_load_use #(.REG_AW(REG_AW), .ZERO_SINK(ZERO_SINK)) u_lu (
      .id_src1    (id_src1),
      .id_src2    (id_src2),
      .ex_dst     (ex_dst),
      .ex_is_load (ex_is_load),
      .hold       (hold)
   );

   assign opnd_a_sel  = opnd_sel[0];
   assign opnd_b_sel  = opnd_sel[1];
   assign pc_wr_en    = ~hold;
   assign ifid_wr_en  = ~hold;
   assign idex_bubble = hold;

endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
   parameter int REG_AW = 5
) (
   input logic [REG_AW-1:0] id_src1,
   input logic [REG_AW-1:0] id_src2,
   input logic [REG_AW-1:0] ex_src1,
   input logic [REG_AW-1:0] ex_dst,
   input logic              ex_is_load,
   input logic [REG_AW-1:0] exm_dst,
   input logic              exm_wr,
   input logic              mwb_wr,
   input logic [1:0]        opnd_a_sel,
   input logic [1:0]        opnd_b_sel,
   input logic              pc_wr_en,
   input logic              ifid_wr_en,
   input logic              idex_bubble
);

   localparam logic [REG_AW-1:0] Z = '0;

   always_comb begin
      // R1 / R3: a qualifying younger match always selects exe/mem
      if (exm_wr && exm_dst == ex_src1 && exm_dst != Z)
         p_exm_wins_r3: assert (opnd_a_sel == 2'b10);
      // R4: register 0 never forwarded
      if (ex_src1 == Z)
         p_zero_src_r4: assert (opnd_a_sel == 2'b00);
      // R5: cleared write flags leave both operands on the register file
      if (!exm_wr && !mwb_wr)
         p_no_wr_r5: assert (opnd_a_sel == 2'b00 && opnd_b_sel == 2'b00);
      // R6: the unused selector code never appears
      p_legal_code_r6: assert (opnd_a_sel != 2'b11 && opnd_b_sel != 2'b11);
      // R8: hold outputs agree with each other
      p_hold_coherent_r8: assert (pc_wr_en == ifid_wr_en && idex_bubble == !pc_wr_en);
      // R8: load to a decode source holds
      if (ex_is_load && ex_dst != Z && (ex_dst == id_src1 || ex_dst == id_src2))
         p_load_use_r8: assert (idex_bubble);
      // R9: no load, no hold
      if (!ex_is_load)
         p_no_load_r9: assert (pc_wr_en && !idex_bubble);
   end

endmodule

bind hz_unit hz_unit_chk #(.REG_AW(REG_AW)) u_chk (
   .id_src1     (id_src1),
   .id_src2     (id_src2),
   .ex_src1     (ex_src1),
   .ex_dst      (ex_dst),
   .ex_is_load  (ex_is_load),
   .exm_dst     (exm_dst),
   .exm_wr      (exm_wr),
   .mwb_wr      (mwb_wr),
   .opnd_a_sel  (opnd_a_sel),
   .opnd_b_sel  (opnd_b_sel),
   .pc_wr_en    (pc_wr_en),
   .ifid_wr_en  (ifid_wr_en),
   .idex_bubble (idex_bubble)
);

// File: tb/hz_unit_bench.sv
`timescale 1ns/1ps
module hz_unit_bench;

   localparam int AW = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [AW-1:0] id_src1 = '0, id_src2 = '0, ex_src1 = '0, ex_src2 = '0;
   logic [AW-1:0] ex_dst = '0, exm_dst = '0, mwb_dst = '0;
   logic          ex_is_load = 1'b0, exm_wr = 1'b0, mwb_wr = 1'b0;
   logic [1:0]    opnd_a_sel, opnd_b_sel;
   logic          pc_wr_en, ifid_wr_en, idex_bubble;

   int checks = 0;
   int errors = 0;

   hz_unit #(.REG_AW(AW)) u_hz_unit (
      .id_src1(id_src1), .id_src2(id_src2),
      .ex_src1(ex_src1), .ex_src2(ex_src2),
      .ex_dst(ex_dst), .ex_is_load(ex_is_load),
      .exm_dst(exm_dst), .exm_wr(exm_wr),
      .mwb_dst(mwb_dst), .mwb_wr(mwb_wr),
      .opnd_a_sel(opnd_a_sel), .opnd_b_sel(opnd_b_sel),
      .pc_wr_en(pc_wr_en), .ifid_wr_en(ifid_wr_en),
      .idex_bubble(idex_bubble)
   );

   function automatic logic [1:0] exp_sel(logic [AW-1:0] s,
                                          logic [AW-1:0] d1, logic w1,
                                          logic [AW-1:0] d2, logic w2);
      if (w1 && d1 != 0 && d1 == s) return 2'b10;
      if (w2 && d2 != 0 && d2 == s) return 2'b01;
      return 2'b00;
   endfunction

   function automatic logic exp_hold(logic [AW-1:0] a, logic [AW-1:0] b,
                                     logic [AW-1:0] d, logic ld);
      return ld && d != 0 && (d == a || d == b);
   endfunction

   task automatic chk(string tag, string what, logic [2:0] act, logic [2:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic apply(logic [AW-1:0] i1, logic [AW-1:0] i2,
                        logic [AW-1:0] e1, logic [AW-1:0] e2,
                        logic [AW-1:0] ed, logic ld,
                        logic [AW-1:0] md, logic mw,
                        logic [AW-1:0] wd, logic ww,
                        string ta, string tb, string th);
      logic h;
      @(posedge clk);
      #1;
      id_src1 = i1; id_src2 = i2; ex_src1 = e1; ex_src2 = e2;
      ex_dst = ed; ex_is_load = ld; exm_dst = md; exm_wr = mw;
      mwb_dst = wd; mwb_wr = ww;
      @(negedge clk);
      chk(ta, "opnd_a_sel", {1'b0, opnd_a_sel}, {1'b0, exp_sel(e1, md, mw, wd, ww)});
      chk(tb, "opnd_b_sel", {1'b0, opnd_b_sel}, {1'b0, exp_sel(e2, md, mw, wd, ww)});
      h = exp_hold(i1, i2, ed, ld);
      chk(th, "hold {pc,ifid,bubble}", {pc_wr_en, ifid_wr_en, idex_bubble}, {~h, ~h, h});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (2) @(posedge clk);
      rst_n = 1'b1;
      // R6 R9: idle state, all fields zero
      apply(0,0, 0,0, 0,0, 0,0, 0,0, "R6", "R6", "R9");
      // R1 R7: exe/mem match on operand A only
      apply(1,2, 5,4, 0,0, 5,1, 0,0, "R1", "R7", "R9");
      // R2: mem/wb match on operand B
      apply(1,2, 3,6, 0,0, 0,0, 6,1, "R6", "R2", "R9");
      // R3: both producers match both operands
      apply(1,2, 7,7, 0,0, 7,1, 7,1, "R3", "R3", "R9");
      // R4: register 0 writes never forward
      apply(0,0, 0,0, 0,1, 0,1, 0,1, "R4", "R4", "R4");
      // R5: exe/mem write flag clear, older producer used
      apply(1,2, 9,9, 0,0, 9,0, 9,1, "R5", "R5", "R9");
      // R5: both flags clear
      apply(1,2, 9,8, 0,0, 9,0, 8,0, "R5", "R5", "R9");
      // R8: load-use on second decode source
      apply(4,3, 0,0, 3,1, 0,0, 0,0, "R6", "R6", "R8");
      // R8: load-use on first decode source
      apply(3,4, 0,0, 3,1, 0,0, 0,0, "R6", "R6", "R8");
      // R9: matching register but not a load
      apply(3,4, 0,0, 3,0, 0,0, 0,0, "R6", "R6", "R9");
      // R9: load with no match
      apply(5,6, 0,0, 3,1, 0,0, 0,0, "R6", "R6", "R9");
      // random, narrow register range
      for (int n = 0; n < 600; n++) begin
         apply(AW'($urandom_range(0,3)), AW'($urandom_range(0,3)),
               AW'($urandom_range(0,3)), AW'($urandom_range(0,3)),
               AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
               AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
               AW'($urandom_range(0,3)), 1'($urandom_range(0,1)),
               "R1/R2/R3/R4/R5/R6", "R7", "R8/R9");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule